// File: doc/BRIEF.md
# PUF Challenge Sequencer

This block runs a delay-based physical unclonable function without any manual or external trigger. After a start pulse it walks an 8-bit challenge through every value from 0 to 255 in ascending order and gives each value one fixed-length time slot. In every slot it does three things in order:

1. It pulses a clear line to the arbiter latch.
2. After a short fixed gap it raises the launch line into the delay chain.
3. After a settle interval it samples the single response bit and raises a one-cycle valid strobe toward a collection buffer.

After the strobe for challenge 255 the sequencer stops on its own and raises a done flag. The done flag stays high until the next start.

The delay chain, the arbiter latch and any clock divider sit outside this block. The slot length, the clear width, the clear-to-launch gap and the settle time are all parameters given in clock cycles. The default slot is 10,000,000 cycles, which is 100 ms at 100 MHz. A simulation can shrink it to a few tens of cycles. The current challenge is also driven on a separate display output.

Top module: `puf_challenge_seq`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the block clears its state. After that edge the outputs are as follows: `latch_clr_o`, `launch_o`, `resp_valid_o`, `resp_bit_o` and `done_o` are 0, and `challenge_o` and `count_o` are 0.
- R2: A `start_i` high while idle begins a run. In the next cycle `latch_clr_o` is 1, `challenge_o` is 0 and `done_o` is 0.
- R3: Each slot opens with `latch_clr_o` high for CLR_CYCLES cycles while `launch_o` is low. `launch_o` rises LAUNCH_GAP cycles after `latch_clr_o` falls. The two lines are never high together.
- R4: `resp_valid_o` is high for exactly one cycle, SETTLE_CYCLES cycles after `launch_o` rises. In that cycle `resp_bit_o` equals `puf_resp_i`; in all other cycles `resp_bit_o` is 0. `launch_o` falls in the cycle after the strobe.
- R5: `challenge_o` and `count_o` carry the same value. It rises by exactly one after each strobe, so a complete run yields exactly 256 strobes with challenges 0, 1, …, 255 in that order.
- R6: Consecutive strobes within a run are SLOT_CYCLES cycles apart, and each new slot opens SLOT_CYCLES cycles after the previous one.
- R7: After the strobe for challenge 255 no further clear, launch or strobe occurs. `done_o` is 1 from the next cycle, and `count_o` holds 255.
- R8: `done_o` stays 1 while idle until the next start. That start clears `done_o` and the counter and begins a new run.
- R9: `start_i` has no effect while a run is in progress or in the single cycle after the final strobe. The counter, the slot timing and the strobes continue unchanged.
- R10: Pulling `rst_n` low in the middle of a run aborts it. The block returns to the reset outputs of R1 and stays idle until a new start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begins a run of 256 challenges when idle |
| puf_resp_i | input | 1 | Response bit from the arbiter latch |
| challenge_o | output | 8 | Challenge applied to the delay-chain selects |
| latch_clr_o | output | 1 | Clear pulse to the arbiter latch |
| launch_o | output | 1 | Launch edge into the delay chain |
| resp_valid_o | output | 1 | One-cycle strobe marking a sampled response |
| resp_bit_o | output | 1 | Sampled response bit, valid with the strobe |
| done_o | output | 1 | All 256 responses delivered |
| count_o | output | 8 | Challenge counter for display |

## Verification
A slot timer that is off by even one count shifts the clear, launch and strobe edges within the first slot after start. A cycle-accurate expected model in the bench exposes such a shift within the first slot, well under SLOT_CYCLES cycles after start. A counter that skips or repeats a value shows up at the very next strobe as a broken ascending sequence. A wrong control state at the end of a run appears within one cycle of the 256th strobe, either as an extra slot or as a missing or late done flag. The bench also injects start pulses and a reset at random points in a run and checks that each behaves as R9 and R10 state.

// File: rtl/puf_seq_pkg.sv
// Package: shared types for the PUF challenge sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package puf_seq_pkg;

    // Control states: idle, slot active (clear/launch/sample), slot remainder, run end.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FIRE = 2'd1,
        ST_WAIT = 2'd2,
        ST_END  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/puf_slot_timer.sv
// Module: puf_slot_timer
// Counts cycles within one challenge slot and decodes the clear window,
// the launch window, the sample point and the last cycle of the slot.
// Assumes: CLR_CYCLES >= 1, LAUNCH_GAP >= 1, SETTLE_CYCLES >= 1, and the
// sample point falls at least two cycles before the slot ends.
module puf_slot_timer #(
    parameter int unsigned SLOT_CYCLES   = 10_000_000,
    parameter int unsigned CLR_CYCLES    = 4,
    parameter int unsigned LAUNCH_GAP    = 2,
    parameter int unsigned SETTLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic clr_win_o,
    output logic launch_win_o,
    output logic sample_o,
    output logic slot_end_o
);
    localparam int unsigned LAUNCH_AT = CLR_CYCLES + LAUNCH_GAP;
    localparam int unsigned SAMPLE_AT = LAUNCH_AT + SETTLE_CYCLES;
    localparam int unsigned TW        = (SLOT_CYCLES > 2) ? $clog2(SLOT_CYCLES) : 1;
    localparam logic [TW-1:0] LAST_T   = TW'(SLOT_CYCLES - 1);
    localparam logic [TW-1:0] CLR_T    = TW'(CLR_CYCLES);
    localparam logic [TW-1:0] LAUNCH_T = TW'(LAUNCH_AT);
    localparam logic [TW-1:0] SAMPLE_T = TW'(SAMPLE_AT);

    logic [TW-1:0] t_q;

    // Purpose: confirm the parameters leave room for the whole sequence in a slot.
    initial begin
        params_ok_chk: assert (CLR_CYCLES >= 1 && LAUNCH_GAP >= 1 && SETTLE_CYCLES >= 1
                               && SAMPLE_AT + 2 <= SLOT_CYCLES);
    end

    // Purpose: slot cycle counter, restarted on clear, wrapping at the slot end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else if (clear_i) begin
            t_q <= '0;
        end else if (run_i) begin
            t_q <= (t_q == LAST_T) ? '0 : t_q + TW'(1);
        end
    end

    // Purpose: decode the windows within the slot from the cycle count.
    always_comb begin
        clr_win_o    = (t_q < CLR_T);
        launch_win_o = (t_q >= LAUNCH_T) && (t_q <= SAMPLE_T);
        sample_o     = (t_q == SAMPLE_T);
        slot_end_o   = (t_q == LAST_T);
    end

    // R6
    t_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_q <= LAST_T);

    // R6
    t_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !clear_i && t_q == LAST_T) |=> (t_q == '0));

    // R6
    t_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !clear_i) |=> $stable(t_q));

endmodule

// File: rtl/puf_chal_counter.sv
// Module: puf_chal_counter
// Holds the current challenge. It clears on request and advances by one on
// each increment, saturating at the all-ones value so that the last
// challenge remains visible after the run ends.
// Assumes: clear and increment are never requested in the same cycle.
module puf_chal_counter #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          inc_i,
    output logic [CW-1:0] cnt_o,
    output logic          at_max_o
);
    localparam logic [CW-1:0] MAX_V = '1;

    logic [CW-1:0] cnt_q;

    // Purpose: challenge register with clear and saturating increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && cnt_q != MAX_V) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign cnt_o    = cnt_q;
    assign at_max_o = (cnt_q == MAX_V);

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i && !at_max_o) |=> (cnt_q == $past(cnt_q) + CW'(1)));

    // R5
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !clr_i) |=> $stable(cnt_q));

    // R7
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (at_max_o && !clr_i) |=> at_max_o);

endmodule

// File: rtl/puf_seq_ctrl.sv
// Module: puf_seq_ctrl
// Control state machine of the sequencer. It starts a run, alternates the
// active slot phase with the slot remainder, advances the challenge at each
// sample point, and ends the run after the last challenge.
// Assumes: the timer sample point lies strictly before the slot end.
module puf_seq_ctrl
    import puf_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic sample_i,
    input  logic slot_end_i,
    input  logic at_max_i,
    output logic fire_o,
    output logic timer_clr_o,
    output logic timer_run_o,
    output logic cnt_clr_o,
    output logic cnt_inc_o,
    output logic done_o
);
    seq_state_e state_q, state_d;
    logic       done_q;
    logic       begin_run;
    logic       last_sample;

    assign begin_run   = (state_q == ST_IDLE) && start_i;
    assign last_sample = (state_q == ST_FIRE) && sample_i && at_max_i;

    // Purpose: next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)    state_d = ST_FIRE;
            ST_FIRE: if (sample_i)   state_d = at_max_i ? ST_END : ST_WAIT;
            ST_WAIT: if (slot_end_i) state_d = ST_FIRE;
            ST_END:                  state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // Purpose: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Purpose: completion flag, set on the last sample, cleared on a new start.
    always_ff @(posedge clk) begin
        if (!rst_n)           done_q <= 1'b0;
        else if (begin_run)   done_q <= 1'b0;
        else if (last_sample) done_q <= 1'b1;
    end

    // Purpose: drive the datapath controls from the state.
    always_comb begin
        fire_o      = (state_q == ST_FIRE);
        timer_clr_o = begin_run;
        timer_run_o = (state_q == ST_FIRE) || (state_q == ST_WAIT);
        cnt_clr_o   = begin_run;
        cnt_inc_o   = (state_q == ST_FIRE) && sample_i;
        done_o      = done_q;
    end

    // R7
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(state_q == ST_FIRE && sample_i && at_max_i));

    // R8
    done_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !start_i) |=> done_q);

    // R7
    end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_END) |=> (state_q == ST_IDLE));

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && start_i && !slot_end_i) |=> (state_q == ST_WAIT));

endmodule

// File: rtl/puf_challenge_seq.sv
// Module: puf_challenge_seq (top)
// Automatic challenge sequencer for a delay-based PUF. It issues 256
// ascending challenges and, in each slot, applies a latch clear, then a
// launch edge, then a one-cycle response strobe.
// Assumes: puf_resp_i is settled by the sample point, and all slot timing
// parameters are given in cycles of clk.
module puf_challenge_seq #(
    parameter int unsigned SLOT_CYCLES   = 10_000_000,
    parameter int unsigned CLR_CYCLES    = 4,
    parameter int unsigned LAUNCH_GAP    = 2,
    parameter int unsigned SETTLE_CYCLES = 16,
    parameter int unsigned CW            = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          puf_resp_i,
    output logic [CW-1:0] challenge_o,
    output logic          latch_clr_o,
    output logic          launch_o,
    output logic          resp_valid_o,
    output logic          resp_bit_o,
    output logic          done_o,
    output logic [CW-1:0] count_o
);
    logic          clr_win, launch_win, sample_pt, slot_end;
    logic          fire, timer_clr, timer_run, cnt_clr, cnt_inc, at_max;
    logic [CW-1:0] cnt;

    puf_slot_timer #(
        .SLOT_CYCLES  (SLOT_CYCLES),
        .CLR_CYCLES   (CLR_CYCLES),
        .LAUNCH_GAP   (LAUNCH_GAP),
        .SETTLE_CYCLES(SETTLE_CYCLES)
    ) timer_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (timer_clr),
        .run_i       (timer_run),
        .clr_win_o   (clr_win),
        .launch_win_o(launch_win),
        .sample_o    (sample_pt),
        .slot_end_o  (slot_end)
    );

    puf_chal_counter #(.CW(CW)) counter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (cnt_clr),
        .inc_i   (cnt_inc),
        .cnt_o   (cnt),
        .at_max_o(at_max)
    );

    puf_seq_ctrl ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .sample_i   (sample_pt),
        .slot_end_i (slot_end),
        .at_max_i   (at_max),
        .fire_o     (fire),
        .timer_clr_o(timer_clr),
        .timer_run_o(timer_run),
        .cnt_clr_o  (cnt_clr),
        .cnt_inc_o  (cnt_inc),
        .done_o     (done_o)
    );

    // Purpose: gate the timer windows with the active slot phase to form the outputs.
    always_comb begin
        latch_clr_o  = fire && clr_win;
        launch_o     = fire && launch_win;
        resp_valid_o = fire && sample_pt;
        resp_bit_o   = fire && sample_pt && puf_resp_i;
        challenge_o  = cnt;
        count_o      = cnt;
    end

    // R3
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(latch_clr_o && launch_o));

    // R3
    launch_after_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(launch_o) |-> $past(!latch_clr_o));

    // R4
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid_o |=> !resp_valid_o);

    // R4
    launch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid_o |=> !launch_o);

    // R5
    chal_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!resp_valid_o && !start_i) |=> $stable(challenge_o));

    // R7
    quiet_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (!latch_clr_o && !launch_o && !resp_valid_o));

endmodule

// File: tb/puf_challenge_seq_tb.sv
module puf_challenge_seq_tb_top;
    localparam int SLOT   = 40;
    localparam int CLRC   = 3;
    localparam int GAP    = 2;
    localparam int SETTLE = 4;
    localparam int LAUNCH_AT = CLRC + GAP;
    localparam int SAMPLE_AT = LAUNCH_AT + SETTLE;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       puf_resp_i;
    logic [7:0] challenge_o, count_o;
    logic       latch_clr_o, launch_o, resp_valid_o, resp_bit_o, done_o;
    logic [31:0] board_seed = 32'h1234_5678;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // expected-behaviour model state
    bit m_run = 0, m_fire = 0, m_done = 0, m_tail = 0;
    int m_t = 0, m_cnt = 0;
    // strobe tracking
    int run_strobes = 0, last_strobe_cyc = 0, last_chal = 0;

    always #5 clk = ~clk;

    function automatic logic puf_model(input logic [7:0] c, input logic [31:0] s);
        logic [31:0] h;
        h = ({24'd0, c} + s) * 32'h9E37_79B1;
        return h[17] ^ h[5];
    endfunction

    assign puf_resp_i = puf_model(challenge_o, board_seed);

    puf_challenge_seq #(
        .SLOT_CYCLES(SLOT), .CLR_CYCLES(CLRC), .LAUNCH_GAP(GAP), .SETTLE_CYCLES(SETTLE), .CW(8)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .puf_resp_i(puf_resp_i),
        .challenge_o(challenge_o), .latch_clr_o(latch_clr_o), .launch_o(launch_o),
        .resp_valid_o(resp_valid_o), .resp_bit_o(resp_bit_o), .done_o(done_o), .count_o(count_o)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Purpose: advance the expected model on each edge, following the requirements.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_run <= 0; m_fire <= 0; m_t <= 0; m_cnt <= 0; m_done <= 0; m_tail <= 0;
        end else if (m_tail) begin
            m_tail <= 0;
        end else if (!m_run) begin
            if (start_i) begin
                m_run <= 1; m_fire <= 1; m_t <= 0; m_cnt <= 0; m_done <= 0;
            end
        end else if (m_fire && m_t == SAMPLE_AT) begin
            if (m_cnt == 255) begin
                m_run <= 0; m_fire <= 0; m_done <= 1; m_tail <= 1;
            end else begin
                m_cnt <= m_cnt + 1; m_fire <= 0;
            end
            m_t <= m_t + 1;
        end else if (m_t == SLOT - 1) begin
            m_t <= 0; m_fire <= 1;
        end else begin
            m_t <= m_t + 1;
        end
    end

    // Purpose: compare the outputs to the model away from the active edge.
    always @(negedge clk) begin
        if (cyc >= 2) begin
            bit e_clr, e_lau, e_val;
            e_clr = m_fire && (m_t < CLRC);
            e_lau = m_fire && (m_t >= LAUNCH_AT) && (m_t <= SAMPLE_AT);
            e_val = m_fire && (m_t == SAMPLE_AT);
            chk(latch_clr_o == e_clr, "R3", "latch_clr_o", int'(latch_clr_o), int'(e_clr));
            chk(launch_o == e_lau, "R3", "launch_o", int'(launch_o), int'(e_lau));
            chk(resp_valid_o == e_val, "R4", "resp_valid_o", int'(resp_valid_o), int'(e_val));
            chk(resp_bit_o == (e_val ? puf_model(8'(m_cnt), board_seed) : 1'b0), "R4", "resp_bit_o",
                int'(resp_bit_o), e_val ? int'(puf_model(8'(m_cnt), board_seed)) : 0);
            chk(count_o == 8'(m_cnt) && challenge_o == 8'(m_cnt), "R5", "challenge/count",
                int'(challenge_o), m_cnt);
            chk(done_o == m_done, "R7", "done_o", int'(done_o), int'(m_done));
            if (rst_n && resp_valid_o) begin
                if (challenge_o == 8'd0) begin
                    run_strobes = 1;
                end else begin
                    run_strobes++;
                    chk(int'(challenge_o) == last_chal + 1, "R5", "ascending challenge",
                        int'(challenge_o), last_chal + 1);
                    chk(cyc - last_strobe_cyc == SLOT, "R6", "strobe spacing",
                        cyc - last_strobe_cyc, SLOT);
                end
                last_chal = int'(challenge_o);
                last_strobe_cyc = cyc;
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done_o && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // Purpose: watchdog, counted as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(latch_clr_o == 0 && launch_o == 0 && resp_valid_o == 0, "R1", "strobes in reset",
            int'(latch_clr_o | launch_o | resp_valid_o), 0);
        chk(done_o == 0 && count_o == 0, "R1", "done/count in reset", int'(count_o) + int'(done_o), 0);
        @(negedge clk) rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R2: start begins run
        start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        chk(latch_clr_o == 1 && challenge_o == 0 && done_o == 0, "R2", "first slot opens",
            int'(latch_clr_o), 1);

        // R9: random start pulses during the run
        while (count_o < 8'd250) begin
            repeat (1 + ($urandom % 300)) @(negedge clk);
            if (count_o < 8'd250) begin
                start_i = 1'b1;
                @(negedge clk) start_i = 1'b0;
            end
        end
        wait_done();
        // R5 / R7: full run
        chk(run_strobes == 256, "R5", "strobes per run", run_strobes, 256);
        chk(count_o == 8'd255 && done_o == 1, "R7", "end of run count", int'(count_o), 255);
        // R9: start in the tail cycle after the last strobe is ignored
        start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        repeat (20 + ($urandom % 50)) @(negedge clk);
        // R8: done holds while idle
        chk(done_o == 1 && latch_clr_o == 0, "R8", "done held idle", int'(done_o), 1);

        // R8: restart, then R10: reset mid-run
        pulse_start();
        chk(done_o == 0 && count_o == 0, "R8", "restart clears done", int'(done_o), 0);
        repeat (1000 + ($urandom % 2000)) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        chk(count_o == 0 && done_o == 0 && latch_clr_o == 0 && launch_o == 0, "R10",
            "abort by reset", int'(count_o), 0);
        repeat (60) @(negedge clk);
        chk(latch_clr_o == 0 && resp_valid_o == 0 && count_o == 0, "R10", "stays idle",
            int'(resp_valid_o), 0);

        // R5 / R6: third run with another response pattern
        board_seed = $urandom;
        pulse_start();
        wait_done();
        chk(run_strobes == 256, "R5", "strobes second full run", run_strobes, 256);
        chk(done_o == 1, "R7", "done after second full run", int'(done_o), 1);
        repeat (10) @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule